// File: doc/BRIEF.md
# I2C Bus Error Guard

This block sits beside the slave side of a two-wire serial interface. It watches the clock and data lines and finds START and STOP conditions. It compares each condition with the position that the transfer engine reports inside the current frame. A condition that arrives in the middle of an address byte, a data byte or an acknowledge slot is a framing violation. The block then latches an error, shows the error status code, raises the interrupt flag and holds the clock line low so that the bus stalls until software steps in.

Software leaves the error through one control write. That write sets the stop-request bit and writes a one to the flag-clear bit in the same access. The block then drops the flag and clears the stop-request bit. It releases the clock line and sends a one-cycle force-idle pulse, which puts the interface back into the not-addressed slave state. It drives no STOP condition onto the bus: only internal state is reset. Outside an error, the block passes every detected START and STOP to the transfer engine as a one-cycle pulse.

Top module: `i2c_buserr_guard`

## Requirements
- R1: After reset, `irq_flag`, `bus_hold`, `stop_req`, `force_idle`, `cond_start` and `cond_stop` are 0, and `status` is 0xF8, the code for no pending information.
- R2: A falling edge of SDA while SCL is high gives exactly one `cond_start` pulse. A rising edge of SDA while SCL is high gives exactly one `cond_stop` pulse. SDA changes while SCL is low give no pulse.
- R3: A START or STOP seen while `xfer_busy` is 1 and `bit_pos` is between 1 and 8 sets `irq_flag` and `bus_hold` to 1 and `status` to 0x00. Values 1 to 7 mean bit slots inside a byte and 8 means the acknowledge slot. Any other non-zero value is treated the same way.
- R4: A START or STOP seen while `xfer_busy` is 0, or while `bit_pos` is 0 (the byte boundary), leaves `irq_flag` at 0 and `status` at 0xF8.
- R5: While the error is pending, detected START and STOP conditions give no `cond_start` or `cond_stop` pulse, and the error stays latched.
- R6: Recovery is a write with `wr_stop`=1 and `wr_clr`=1 while the error is pending. After it, `irq_flag`, `bus_hold` and `stop_req` are 0, `status` is 0xF8, and `force_idle` is high for exactly one cycle.
- R7: While the error is pending, a write that sets only one of `wr_stop` and `wr_clr` leaves the error pending. `stop_req` takes the written `wr_stop` value.
- R8: `force_idle` pulses only on recovery from a pending error. A write with `wr_stop`=1 and `wr_clr`=1 while no error is pending gives no pulse and leaves `stop_req` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| xfer_busy | input | 1 | Transfer engine is inside a frame |
| bit_pos | input | 4 | Slot in the current byte: 0 boundary, 1..7 bits, 8 acknowledge |
| wr_en | input | 1 | Control write strobe |
| wr_stop | input | 1 | Stop-request value carried by the write |
| wr_clr | input | 1 | Write one to clear the interrupt flag |
| status | output | 8 | Status code: 0x00 bus error, 0xF8 nothing pending |
| irq_flag | output | 1 | Interrupt flag, set on a bus error |
| bus_hold | output | 1 | Hold SCL low while the error is pending |
| stop_req | output | 1 | Stored stop-request control bit |
| force_idle | output | 1 | One-cycle pulse that returns the interface to not-addressed slave |
| cond_start | output | 1 | START detected (suppressed while the error is pending) |
| cond_stop | output | 1 | STOP detected (suppressed while the error is pending) |

## Verification
The assertions assume that `xfer_busy` and `bit_pos` stay steady for the few cycles between a line change and its detection, and that SCL and SDA never change in the same cycle. Otherwise a condition could be judged against a shifted position. The stimulus follows both rules by construction. It changes the lines one at a time with several idle cycles between changes, and it sets the frame position before shaping each condition. Random runs vary the busy flag, the slot number and the kind of condition, and a recovery write follows every error, so the pending-error gating and the recovery path both run many times.

// File: rtl/i2cbe_pkg.sv
package i2cbe_pkg;

  localparam int unsigned BITS_PER_BYTE = 8;
  localparam int unsigned POS_W = $clog2(BITS_PER_BYTE + 1);

  localparam logic [7:0] CODE_BUS_ERR = 8'h00;
  localparam logic [7:0] CODE_NO_INFO = 8'hF8;

  typedef enum logic [0:0] {
    GUARD_WATCH = 1'b0,
    GUARD_ERROR = 1'b1
  } guard_state_t;

  // A condition is a framing violation when a transfer is running and the
  // engine is not sitting on a byte boundary.
  function automatic logic pos_is_illegal(input logic busy,
                                          input logic [POS_W-1:0] pos);
    return busy && (pos != '0);
  endfunction

  function automatic logic [7:0] status_of(input logic pending);
    return pending ? CODE_BUS_ERR : CODE_NO_INFO;
  endfunction

  function automatic logic is_start_edge(input logic scl_prev, input logic scl_now,
                                         input logic sda_prev, input logic sda_now);
    return scl_prev && scl_now && sda_prev && !sda_now;
  endfunction

  function automatic logic is_stop_edge(input logic scl_prev, input logic scl_now,
                                        input logic sda_prev, input logic sda_now);
    return scl_prev && scl_now && !sda_prev && sda_now;
  endfunction

endpackage

// File: rtl/i2cbe_cond.sv
module i2cbe_cond
  import i2cbe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_seen,
  output logic stop_seen
);

  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] chain [SYNC_STAGES];
  logic [NLINES-1:0] now_v;
  logic [NLINES-1:0] prev_v;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '1;
        else        chain[g] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '1;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign now_v = chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_v <= '1;
    else        prev_v <= now_v;
  end

  assign start_seen = is_start_edge(prev_v[1], now_v[1], prev_v[0], now_v[0]);
  assign stop_seen  = is_stop_edge(prev_v[1], now_v[1], prev_v[0], now_v[0]);

  AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen)); // R2

endmodule

// File: rtl/i2cbe_judge.sv
module i2cbe_judge
  import i2cbe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_seen,
  input  logic             stop_seen,
  input  logic             xfer_busy,
  input  logic [POS_W-1:0] bit_pos,
  input  logic             wr_en,
  input  logic             wr_stop,
  input  logic             wr_clr,
  output logic             pending,
  output logic             stop_bit,
  output logic             idle_pulse,
  output logic             start_pulse,
  output logic             stop_pulse
);

  guard_state_t state_q, state_d;
  logic any_cond;
  logic fault_hit;
  logic recover_hit;

  assign pending     = (state_q == GUARD_ERROR);
  assign any_cond    = start_seen || stop_seen;
  assign fault_hit   = any_cond && !pending && pos_is_illegal(xfer_busy, bit_pos);
  assign recover_hit = pending && wr_en && wr_stop && wr_clr;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GUARD_WATCH: if (fault_hit)   state_d = GUARD_ERROR;
      GUARD_ERROR: if (recover_hit) state_d = GUARD_WATCH;
      default:                      state_d = GUARD_WATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= GUARD_WATCH;
      stop_bit    <= 1'b0;
      idle_pulse  <= 1'b0;
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
    end else begin
      state_q     <= state_d;
      idle_pulse  <= recover_hit;
      start_pulse <= start_seen && !pending;
      stop_pulse  <= stop_seen && !pending;
      if (recover_hit)  stop_bit <= 1'b0;
      else if (wr_en)   stop_bit <= wr_stop;
    end
  end

  AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> pending); // R3
  AST_LEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && any_cond && !pos_is_illegal(xfer_busy, bit_pos)) |=> !pending); // R4
  AST_NO_EVT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || stop_pulse) |-> !$past(pending)); // R5
  AST_RECOVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    recover_hit |=> (!pending && !stop_bit && idle_pulse)); // R6
  AST_IDLE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |=> !idle_pulse); // R6
  AST_HALF_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && wr_en && !(wr_stop && wr_clr)) |=> (pending && stop_bit == $past(wr_stop))); // R7
  AST_IDLE_ONLY_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |-> $past(pending)); // R8

endmodule

// File: rtl/i2c_buserr_guard.sv
module i2c_buserr_guard
  import i2cbe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             xfer_busy,
  input  logic [POS_W-1:0] bit_pos,
  input  logic             wr_en,
  input  logic             wr_stop,
  input  logic             wr_clr,
  output logic [7:0]       status,
  output logic             irq_flag,
  output logic             bus_hold,
  output logic             stop_req,
  output logic             force_idle,
  output logic             cond_start,
  output logic             cond_stop
);

  logic start_seen;
  logic stop_seen;
  logic pending;

  i2cbe_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .start_seen (start_seen),
    .stop_seen  (stop_seen)
  );

  i2cbe_judge u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_seen  (start_seen),
    .stop_seen   (stop_seen),
    .xfer_busy   (xfer_busy),
    .bit_pos     (bit_pos),
    .wr_en       (wr_en),
    .wr_stop     (wr_stop),
    .wr_clr      (wr_clr),
    .pending     (pending),
    .stop_bit    (stop_req),
    .idle_pulse  (force_idle),
    .start_pulse (cond_start),
    .stop_pulse  (cond_stop)
  );

  assign status   = status_of(pending);
  assign irq_flag = pending;
  assign bus_hold = pending;

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cond_start && cond_stop)); // R2
  AST_IDLE_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    force_idle |-> (!bus_hold && status == CODE_NO_INFO)); // R6

endmodule

// File: tb/sim_i2c_buserr_guard.sv
`timescale 1ns/1ps
module sim_i2c_buserr_guard;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic xfer_busy = 1'b0;
  logic [3:0] bit_pos = '0;
  logic wr_en = 1'b0, wr_stop = 1'b0, wr_clr = 1'b0;
  logic [7:0] status;
  logic irq_flag, bus_hold, stop_req, force_idle, cond_start, cond_stop;

  int n_chk = 0, n_fail = 0;
  int cnt_start = 0, cnt_stop = 0, cnt_idle = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_buserr_guard u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .xfer_busy(xfer_busy), .bit_pos(bit_pos),
    .wr_en(wr_en), .wr_stop(wr_stop), .wr_clr(wr_clr),
    .status(status), .irq_flag(irq_flag), .bus_hold(bus_hold),
    .stop_req(stop_req), .force_idle(force_idle),
    .cond_start(cond_start), .cond_stop(cond_stop)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cond_start) cnt_start++;
      if (cond_stop)  cnt_stop++;
      if (force_idle) cnt_idle++;
    end
  end

  function automatic bit exp_error(input bit busy, input int pos);
    return busy && (pos != 0);
  endfunction

  function automatic int exp_status(input bit err);
    return err ? 8'h00 : 8'hF8;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shape one START (is_start=1) or STOP with line changes spaced apart
  task automatic make_cond(input bit is_start);
    @(negedge clk); scl_in = 1'b0; idle(4);
    sda_in = is_start; idle(4);
    scl_in = 1'b1; idle(4);
    sda_in = ~is_start; idle(6);
  endtask

  task automatic host_write(input bit stp, input bit clr);
    @(negedge clk); wr_en = 1'b1; wr_stop = stp; wr_clr = clr;
    @(negedge clk); wr_en = 1'b0; wr_stop = 1'b0; wr_clr = 1'b0;
    idle(2);
  endtask

  initial begin : watchdog
    #1ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int s0, p0, i0;
    void'($urandom(32'h1C2B_5EED));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk(irq_flag == 0, "R1 irq_flag", irq_flag, 0);
    chk(status == 8'hF8, "R1 status", status, 8'hF8);
    chk(bus_hold == 0 && stop_req == 0, "R1 hold/stop", {bus_hold, stop_req}, 0);
    chk(force_idle == 0 && cond_start == 0 && cond_stop == 0, "R1 pulses",
        {force_idle, cond_start, cond_stop}, 0);

    // R2 / R4 idle bus START and STOP
    s0 = cnt_start; p0 = cnt_stop;
    make_cond(1'b1);
    chk(cnt_start == s0 + 1 && cnt_stop == p0, "R2 start pulse", cnt_start - s0, 1);
    chk(irq_flag == 0, "R4 idle start legal", irq_flag, 0);
    s0 = cnt_start; p0 = cnt_stop;
    make_cond(1'b0);
    chk(cnt_stop == p0 + 1 && cnt_start == s0, "R2 stop pulse", cnt_stop - p0, 1);

    // R2 SDA moves while SCL low only
    s0 = cnt_start; p0 = cnt_stop;
    @(negedge clk); scl_in = 1'b0; idle(4);
    sda_in = 1'b0; idle(4); sda_in = 1'b1; idle(4); sda_in = 1'b0; idle(4);
    scl_in = 1'b1; idle(6);
    chk(cnt_start == s0 && cnt_stop == p0, "R2 no event with SCL low",
        (cnt_start - s0) + (cnt_stop - p0), 0);

    // R4 byte boundary while busy
    xfer_busy = 1'b1; bit_pos = 4'd0;
    make_cond(1'b1);
    chk(irq_flag == 0 && status == 8'hF8, "R4 boundary legal", status, 8'hF8);

    // R3 STOP in the acknowledge slot
    bit_pos = 4'd8;
    make_cond(1'b0);
    chk(irq_flag == 1 && bus_hold == 1, "R3 flag on ack-slot stop", irq_flag, 1);
    chk(status == 8'h00, "R3 status error", status, 8'h00);

    // R5 events masked while pending
    s0 = cnt_start; p0 = cnt_stop;
    bit_pos = 4'd0; xfer_busy = 1'b0;
    make_cond(1'b1);
    make_cond(1'b0);
    chk(cnt_start == s0 && cnt_stop == p0, "R5 masked events",
        (cnt_start - s0) + (cnt_stop - p0), 0);
    chk(irq_flag == 1, "R5 still pending", irq_flag, 1);

    // R7 half writes
    i0 = cnt_idle;
    host_write(1'b0, 1'b1);
    chk(irq_flag == 1 && stop_req == 0, "R7 clear only", irq_flag, 1);
    host_write(1'b1, 1'b0);
    chk(irq_flag == 1 && stop_req == 1, "R7 stop only", {irq_flag, stop_req}, 3);
    chk(cnt_idle == i0, "R8 no idle on half write", cnt_idle - i0, 0);

    // R6 recovery
    host_write(1'b1, 1'b1);
    chk(irq_flag == 0 && bus_hold == 0 && stop_req == 0, "R6 cleared",
        {irq_flag, bus_hold, stop_req}, 0);
    chk(status == 8'hF8, "R6 status back", status, 8'hF8);
    chk(cnt_idle == i0 + 1, "R6 single idle pulse", cnt_idle - i0, 1);

    // R8 recovery write with nothing pending
    i0 = cnt_idle;
    host_write(1'b1, 1'b1);
    chk(cnt_idle == i0 && stop_req == 1, "R8 no idle without error", cnt_idle - i0, 0);
    host_write(1'b0, 1'b0);
    chk(stop_req == 0, "R7 stop written back", stop_req, 0);

    // random sweep
    for (int k = 0; k < 60; k++) begin
      bit busy, kind, ee;
      int pos;
      busy = 1'($urandom_range(0, 1));
      pos  = $urandom_range(0, 9);
      kind = 1'($urandom_range(0, 1));
      xfer_busy = busy; bit_pos = 4'(pos);
      s0 = cnt_start; p0 = cnt_stop;
      make_cond(kind);
      ee = exp_error(busy, pos);
      chk(irq_flag == ee, ee ? "R3 random flag" : "R4 random no flag", irq_flag, ee);
      chk(status == exp_status(ee), "R3 random status", status, exp_status(ee));
      chk(kind ? (cnt_start == s0 + 1) : (cnt_stop == p0 + 1), "R2 random pulse",
          kind ? cnt_start - s0 : cnt_stop - p0, 1);
      if (irq_flag) begin
        i0 = cnt_idle;
        host_write(1'b1, 1'b1);
        chk(irq_flag == 0 && cnt_idle == i0 + 1 && stop_req == 0, "R6 random recover",
            cnt_idle - i0, 1);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule